// File: doc/BRIEF.md
# Single-to-Double Precision Widening Unit

The unit takes a 32-bit single-precision bit pattern together with a one-cycle start strobe and returns the equivalent 64-bit double-precision pattern as two 32-bit halves, marked by a one-cycle done strobe. The conversion is always exact, so no rounding is involved. Zeros, normal numbers, infinities and NaNs are handled in one cycle: the fields are either copied or the exponent is rebiased.

A subnormal single (nonzero, exponent field zero) has no hidden bit, so it becomes a normal double only after normalisation. A small sequential loop handles this. It shifts the fraction left one place per cycle and lowers the exponent by one each time, until the leading one reaches the hidden-bit position. The loop is busy for at most 23 shift steps, and the unit ignores a start that arrives while the loop is running. Results stay on the outputs until the next conversion completes.

Top module: `fp_widen_s2d`

## Requirements
- R1: While reset is held and just after it is released, `hi_o`, `lo_o` and `done_o` are all zero.
- R2: A zero input (bits 30:0 all zero) gives `hi_o` = the input sign in bit 31 with all other bits zero and `lo_o` = 0. `done_o` is high in the cycle after the start edge (latency 1).
- R3: A normal input with exponent field e in bits 30:23 (1..254) and fraction f in bits 22:0 gives a double with sign in bit 63, exponent e+896 in bits 62:52 and fraction f<<29 in bits 51:0. Bits 63:32 appear on `hi_o` and bits 31:0 appear on `lo_o`. The latency is 1.
- R4: An input with exponent field 255 (infinity or NaN) gives double exponent 2047 and keeps the sign and the fraction f<<29 unchanged. The latency is 1.
- R5: A subnormal input (exponent field 0, fraction nonzero, leading one at fraction bit p) gives double exponent 874+p and fraction ((f << (23-p)) mod 2^23) << 29. No result ever has a zero exponent with a nonzero fraction.
- R6: For a subnormal input, `done_o` is first high after 24-p rising edges, counting the start edge as the first. The worst case is 24, reached when p = 0.
- R7: `done_o` is high for exactly one cycle per accepted conversion.
- R8: A start strobe that arrives while a subnormal conversion is in progress is ignored: it produces no done pulse, and the running result is not disturbed.
- R9: `hi_o` and `lo_o` keep their value in every cycle in which `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe; `word_i` is sampled when this is high and the unit is idle |
| word_i | input | 32 | Single-precision input pattern |
| hi_o | output | 32 | Upper half of the double result (sign, exponent, top 20 fraction bits) |
| lo_o | output | 32 | Lower half of the double result |
| done_o | output | 1 | One-cycle pulse when the result is valid |

## Verification
An error in the normalising loop shows at the ports in two ways. A wrong exponent count shows up as a double exponent that differs from 874+p. A wrong termination test moves the done pulse away from edge 24-p, or leaves it out, so the fault appears within at most 24 cycles of the start. The bench places the leading one at every fraction position, with several lower-bit patterns and both signs. It also sweeps every normal exponent, so any off-by-one in the rebias constant or in the shift count shows up in the first conversion that exercises it. A start accepted while busy would show as an extra done pulse, or as a result that is not the subnormal's, within a few cycles.

// File: rtl/widen_pkg.sv
package widen_pkg;
  // Class of the incoming single-precision pattern
  typedef enum logic [1:0] {
    CK_ZERO = 2'd0,
    CK_SUB  = 2'd1,
    CK_NORM = 2'd2,
    CK_TOP  = 2'd3
  } src_kind_t;
endpackage

// File: rtl/wd_classify.sv
module wd_classify
  import widen_pkg::*;
#(
  parameter int SE = 8,
  parameter int SF = 23
) (
  input  logic [SE+SF:0] word_i,
  output src_kind_t      kind_o
);
  logic [SE-1:0] exp_f;
  logic [SF-1:0] frac_f;

  assign exp_f  = word_i[SE+SF-1:SF];
  assign frac_f = word_i[SF-1:0];

  always_comb begin
    if (exp_f == '0) kind_o = (frac_f == '0) ? CK_ZERO : CK_SUB;
    else if (&exp_f) kind_o = CK_TOP;
    else             kind_o = CK_NORM;
  end
endmodule

// File: rtl/wd_norm_loop.sv
module wd_norm_loop #(
  parameter int SF        = 23,
  parameter int DE        = 11,
  parameter int START_EXP = 897
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [SF-1:0] frac_i,
  output logic          busy_o,
  output logic          hit_o,
  output logic [SF-1:0] frac_o,
  output logic [DE-1:0] exp_o
);
  localparam int CW = $clog2(SF + 1);

  logic [SF:0]   mant_q;
  logic [DE-1:0] exp_q;
  logic          busy_q;
  logic [CW-1:0] steps_q;

  // Event: leading one has reached the hidden-bit position
  assign hit_o  = busy_q & mant_q[SF];
  assign busy_o = busy_q;
  assign frac_o = mant_q[SF-1:0];
  assign exp_o  = exp_q;

  // The first shift is folded into the load: a subnormal never has the
  // hidden bit set, so the loaded value is pre-shifted by one.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mant_q  <= '0;
      exp_q   <= '0;
      busy_q  <= 1'b0;
      steps_q <= '0;
    end else if (load_i) begin
      mant_q  <= {frac_i, 1'b0};
      exp_q   <= DE'(START_EXP - 1);
      busy_q  <= 1'b1;
      steps_q <= '0;
    end else if (busy_q) begin
      if (mant_q[SF]) begin
        busy_q <= 1'b0;
      end else begin
        mant_q  <= mant_q << 1;
        exp_q   <= exp_q - 1'b1;
        steps_q <= steps_q + 1'b1;
      end
    end
  end

  assert_loop_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> steps_q <= CW'(SF - 1));

  assert_exp_track_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (exp_q + DE'(steps_q)) == DE'(START_EXP - 1));

  assert_load_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> frac_i != '0);

  assert_hit_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o && !load_i |=> !busy_q);
endmodule

// File: rtl/fp_widen_s2d.sv
module fp_widen_s2d
  import widen_pkg::*;
#(
  parameter int SE = 8,
  parameter int SF = 23,
  parameter int DE = 11,
  parameter int DF = 52
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [SE+SF:0]           word_i,
  output logic [(1+DE+DF)/2-1:0]   hi_o,
  output logic [(1+DE+DF)/2-1:0]   lo_o,
  output logic                     done_o
);
  localparam int SW        = 1 + SE + SF;
  localparam int DW        = 1 + DE + DF;
  localparam int HW        = DW / 2;
  localparam int SBIAS     = (1 << (SE - 1)) - 1;
  localparam int DBIAS     = (1 << (DE - 1)) - 1;
  localparam int REBIAS    = DBIAS - SBIAS;
  localparam int START_EXP = DBIAS - (SBIAS - 1);

  function automatic logic [DE-1:0] rebias(input logic [SE-1:0] e);
    if (&e) return '1;
    return DE'(e) + DE'(REBIAS);
  endfunction

  function automatic logic [DW-1:0] pack(input logic s, input logic [DE-1:0] e,
                                         input logic [SF-1:0] f);
    return {s, e, f, {(DF - SF){1'b0}}};
  endfunction

  src_kind_t     kind;
  logic          loop_busy, loop_hit;
  logic [SF-1:0] loop_frac;
  logic [DE-1:0] loop_exp;
  logic          accept, load_sub;
  logic          in_sign;
  logic [SE-1:0] in_exp;
  logic [SF-1:0] in_frac;
  logic          sign_q;
  logic [DW-1:0] res_q;
  logic          done_q;

  assign in_sign  = word_i[SW-1];
  assign in_exp   = word_i[SW-2:SF];
  assign in_frac  = word_i[SF-1:0];
  assign accept   = start_i & ~loop_busy;
  assign load_sub = accept & (kind == CK_SUB);

  wd_classify #(.SE(SE), .SF(SF)) u_cls (
    .word_i (word_i),
    .kind_o (kind)
  );

  wd_norm_loop #(.SF(SF), .DE(DE), .START_EXP(START_EXP)) u_loop (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_sub),
    .frac_i (in_frac),
    .busy_o (loop_busy),
    .hit_o  (loop_hit),
    .frac_o (loop_frac),
    .exp_o  (loop_exp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q  <= '0;
      done_q <= 1'b0;
      sign_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (loop_hit) begin
        res_q  <= pack(sign_q, loop_exp, loop_frac);
        done_q <= 1'b1;
      end else if (accept) begin
        unique case (kind)
          CK_ZERO: begin
            res_q  <= pack(in_sign, '0, '0);
            done_q <= 1'b1;
          end
          CK_SUB:  sign_q <= in_sign;
          default: begin
            res_q  <= pack(in_sign, rebias(in_exp), in_frac);
            done_q <= 1'b1;
          end
        endcase
      end
    end
  end

  assign hi_o   = res_q[DW-1:HW];
  assign lo_o   = res_q[HW-1:0];
  assign done_o = done_q;

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(res_q));

  assert_no_dp_subnormal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && (res_q[DW-2:DF] == '0) |-> res_q[DF-1:0] == '0);

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && loop_busy && !loop_hit |=> !done_q);

  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !(accept && kind != CK_SUB) |=> !done_q);
endmodule

// File: tb/sim_fp_widen_s2d.sv
`timescale 1ns/1ps
module sim_fp_widen_s2d;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] word_i = '0;
  logic [31:0] hi_o, lo_o;
  logic        done_o;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fp_widen_s2d u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_i(word_i),
    .hi_o(hi_o), .lo_o(lo_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected double pattern and latency computed arithmetically
  task automatic model(input logic [31:0] w, output logic [63:0] res,
                       output int lat, output string req);
    logic s = w[31];
    int   e = int'(w[30:23]);
    logic [22:0] f = w[22:0];
    int p = 0;
    logic [22:0] nf;
    if (e == 0 && f == 0) begin
      res = {s, 63'd0}; lat = 1; req = "R2";
    end else if (e == 0) begin
      for (int i = 0; i < 23; i++) if (f[i]) p = i;
      nf  = f << (23 - p);
      res = {s, 11'(874 + p), nf, 29'd0};
      lat = 24 - p; req = "R5";
    end else if (e == 255) begin
      res = {s, 11'h7FF, f, 29'd0}; lat = 1; req = "R4";
    end else begin
      res = {s, 11'(e + 896), f, 29'd0}; lat = 1; req = "R3";
    end
  endtask

  task automatic conv(input logic [31:0] w);
    logic [63:0] exp_res;
    int lat, c;
    string req;
    model(w, exp_res, lat, req);
    @(negedge clk); start_i = 1'b1; word_i = w;
    @(negedge clk); start_i = 1'b0;
    c = 1;
    while (!done_o && c < 40) begin @(negedge clk); c++; end
    chk(c == lat && done_o, (req == "R5") ? "R6" : req, "latency",
        64'(c), 64'(lat));
    chk({hi_o, lo_o} === exp_res, req, "result", {hi_o, lo_o}, exp_res);
    @(negedge clk);
    chk(!done_o, "R7", "done one cycle", 64'(done_o), 64'd0);
    chk({hi_o, lo_o} === exp_res, "R9", "hold", {hi_o, lo_o}, exp_res);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    repeat (3) @(negedge clk);
    chk({hi_o, lo_o, done_o} === 65'd0, "R1", "in reset", {hi_o, lo_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({hi_o, lo_o, done_o} === 65'd0, "R1", "after reset", {hi_o, lo_o}, 64'd0);

    conv(32'h0000_0000);  // R2 positive zero
    conv(32'h8000_0000);  // R2 negative zero

    // R5 / R6: leading one at every position, several lower patterns, both signs
    for (int p = 0; p < 23; p++) begin
      for (int s = 0; s < 2; s++) begin
        logic [22:0] one  = 23'd1 << p;
        conv({s[0], 8'd0, one});
        conv({s[0], 8'd0, one | (one - 23'd1)});
        conv({s[0], 8'd0, one | ((one - 23'd1) & 23'h55_5555)});
      end
    end

    // R3 / R4: every exponent, two fraction patterns, alternating sign
    for (int e = 1; e < 256; e++) begin
      conv({e[0], 8'(e), 23'h00_0007});
      conv({~e[0], 8'(e), 23'h7A_5C3B});
    end
    conv(32'h7F80_0000);  // R4 +inf
    conv(32'hFFC0_0001);  // R4 NaN with payload

    // R8: start during a running subnormal conversion is ignored
    @(negedge clk); start_i = 1'b1; word_i = 32'h0000_0001;
    @(negedge clk); start_i = 1'b0;
    repeat (4) @(negedge clk);
    start_i = 1'b1; word_i = 32'h3F80_0000;
    @(negedge clk); start_i = 1'b0;
    chk(!done_o, "R8", "no done after busy start", 64'(done_o), 64'd0);
    begin
      int c = 6;
      while (!done_o && c < 40) begin @(negedge clk); c++; end
      chk(c == 24, "R8", "busy start kept latency", 64'(c), 64'd24);
    end
    r = {1'b0, 11'd874, 52'd0};
    chk({hi_o, lo_o} === r, "R8", "result of first word", {hi_o, lo_o}, r);
    repeat (5) begin
      @(negedge clk);
      chk(!done_o, "R8", "no extra done", 64'(done_o), 64'd0);
    end
    chk({hi_o, lo_o} === r, "R9", "hold after idle", {hi_o, lo_o}, r);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule